// File: doc/BRIEF.md
# Multi-Channel Interrupt Source Multiplexer

This block lets a group of level-sensitive peripheral interrupt lines reach a parent interrupt controller through a small number of output channels. Every source line is presented to every channel at once. Each channel holds its own enable mask and drives one active-high output. The output is asserted while at least one source that the channel has enabled is high. Software steers a source to an output by setting that source's bit in the chosen channel's mask. The same source may be enabled in several channels at once.

Software reaches the block through a plain 32-bit read/write bus that covers a 4 KB window. Every channel owns a 0x40-byte slot in that window. Each slot holds a read/write enable register and a read-only pending view. The pending view shows the sources that are active and enabled for that channel right now. It has no sticky state, so a source is cleared at the peripheral that raised it and not here. Source inputs are taken to be synchronous to the block clock.

Top module: `irq_fanout_mux`

## Requirements
- R1: After reset every enable register reads 0 and every channel output is low.
- R2: The enable register of channel n (0 to 7) is at byte offset 0x10 + 0x40*n. A write stores all 32 data bits, and a read returns the last value written. Bit i of the register belongs to source i.
- R3: The pending register of channel n is at byte offset 0x20 + 0x40*n. A read returns the source inputs ANDed with that channel's enable mask, for the same cycle. It keeps no history, so a bit clears as soon as its source drops.
- R4: Writes to a pending register change no enable mask and no output.
- R5: On each rising clock edge, output n takes the OR of (sources AND mask of channel n), using the mask as updated by any write on that edge. A source change therefore reaches the output one clock later.
- R6: Writing zero to a channel's enable register drives that channel's output low on the same clock edge that takes the write.
- R7: Any source can be routed to any channel. One source enabled in several channels asserts all of them. A write to one channel's registers leaves every other channel unchanged.
- R8: A read of any offset that is not an enable or pending register returns 0. This covers other offsets inside a slot, unaligned addresses and slots beyond channel 7. Writes to such offsets have no effect.
- R9: Each access completes in the cycle it is presented. Read data is valid in that same cycle, and write data takes effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources, synchronous to clk |
| bus_sel_i | input | 1 | Access strobe |
| bus_wr_i | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr_i | input | 12 | Byte address inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 8 | Active-high channel outputs, one per channel |

## Verification
The bench drives several kinds of source patterns:
- A single source enabled in one channel. This shows that the output follows the mask.
- A source enabled in several channels at once. This separates true fan-out from decoding by channel.
- Sources that are active but masked. This confirms that masking blocks both the pending view and the output.
- Sources that rise and fall while the masks stay fixed. Sampling before and after the clock edge confirms the one-cycle latency and shows that nothing is held sticky.

Distinct values are written to every channel. This exposes crossed register slots and stride errors. Writes to pending and to unmapped offsets separate decoding that ignores those accesses from decoding that aliases them onto a mask.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    // Kind of register selected by a bus address
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MASK = 2'd1,
        ACC_PEND = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned NUM_CHAN    = 8,
    parameter int unsigned CHAN_STRIDE = 64,
    parameter int unsigned MASK_OFS    = 16,
    parameter int unsigned PEND_OFS    = 32,
    localparam int unsigned SLOT_W     = $clog2(CHAN_STRIDE),
    localparam int unsigned FIELD_W    = ADDR_W - SLOT_W,
    localparam int unsigned CIDX_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output acc_kind_e         kind_o,
    output logic [CIDX_W-1:0] chan_o
);
    localparam logic [SLOT_W-1:0] MASK_L = SLOT_W'(MASK_OFS);
    localparam logic [SLOT_W-1:0] PEND_L = SLOT_W'(PEND_OFS);

    logic [FIELD_W-1:0] field;
    logic [SLOT_W-1:0]  ofs;
    logic               in_range;

    always_comb begin
        field    = addr_i[ADDR_W-1:SLOT_W];
        ofs      = addr_i[SLOT_W-1:0];
        in_range = (32'(field) < NUM_CHAN);
        chan_o   = field[CIDX_W-1:0];
        kind_o   = ACC_NONE;
        if (in_range && ofs == MASK_L) kind_o = ACC_MASK;
        if (in_range && ofs == PEND_L) kind_o = ACC_PEND;
    end
endmodule

// File: rtl/irqm_channel.sv
module irqm_channel #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               irq;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wdata_i;
        st_d.irq = |(src_i & st_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign pend_o = src_i & st_q.mask;
    assign irq_o  = st_q.irq;

    // Output level tracks sources of the previous cycle and the current mask
    p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(src_i) & mask_o)));

    // A zero mask write clears the output at the edge that takes it
    p_zero_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i == '0) |=> !irq_o);

    // Mask only changes when written
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux
    import irqm_pkg::*;
#(
    parameter int unsigned NUM_CHAN    = 8,
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned CHAN_STRIDE = 64,
    parameter int unsigned MASK_OFS    = 16,
    parameter int unsigned PEND_OFS    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic [NUM_CHAN-1:0] irq_o
);
    localparam int unsigned CIDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

    acc_kind_e          kind;
    logic [CIDX_W-1:0]  chan;
    logic [NUM_CHAN-1:0] wr_vec;
    logic [NUM_SRC-1:0] mask_a [NUM_CHAN];
    logic [NUM_SRC-1:0] pend_a [NUM_CHAN];

    irqm_decode #(
        .ADDR_W(ADDR_W), .NUM_CHAN(NUM_CHAN), .CHAN_STRIDE(CHAN_STRIDE),
        .MASK_OFS(MASK_OFS), .PEND_OFS(PEND_OFS)
    ) u_decode (
        .addr_i(bus_addr_i),
        .kind_o(kind),
        .chan_o(chan)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        assign wr_vec[c] = bus_sel_i && bus_wr_i && kind == ACC_MASK
                           && 32'(chan) == c;
        irqm_channel #(.NUM_SRC(NUM_SRC)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i),
            .wr_i   (wr_vec[c]),
            .wdata_i(bus_wdata_i[NUM_SRC-1:0]),
            .mask_o (mask_a[c]),
            .pend_o (pend_a[c]),
            .irq_o  (irq_o[c])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_wr_i) begin
            if (kind == ACC_MASK) bus_rdata_o = DATA_W'(mask_a[chan]);
            if (kind == ACC_PEND) bus_rdata_o = DATA_W'(pend_a[chan]);
        end
    end

    // At most one channel mask is written per access
    p_one_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    // Unmapped reads return zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && kind == ACC_NONE) |-> bus_rdata_o == '0);
endmodule

// File: tb/irq_fanout_mux_tb.sv
module irq_fanout_mux_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int n_chk = 0, n_bad = 0;
    logic [31:0] mdl [8];

    always #5 clk = ~clk;

    irq_fanout_mux u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] a_mask(input int c); return 12'(16 + 64 * c); endfunction
    function automatic logic [11:0] a_pend(input int c); return 12'(32 + 64 * c); endfunction

    function automatic logic [7:0] exp_irq();
        logic [7:0] r;
        for (int c = 0; c < 8; c++) r[c] = |(src & mdl[c]);
        return r;
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src = v;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        for (int c = 0; c < 8; c++) begin
            bus_read(a_mask(c), d);
            chk("R1 mask after reset", d, 32'h0);
        end
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        for (int c = 0; c < 8; c++) begin
            mdl[c] = 32'hA5000000 ^ (32'h01010101 << c) ^ 32'(c);
            bus_write(a_mask(c), mdl[c]);
        end
        for (int c = 0; c < 8; c++) begin
            bus_read(a_mask(c), d);
            chk("R2 R7 mask readback", d, mdl[c]);
        end
        for (int c = 0; c < 8; c++) begin
            mdl[c] = 32'h0;
            bus_write(a_mask(c), 32'h0);
        end
    endtask

    task automatic t_pending();
        logic [31:0] d;
        mdl[3] = 32'h0000_F0F0;
        bus_write(a_mask(3), mdl[3]);
        set_src(32'h0000_FF00);
        bus_read(a_pend(3), d);
        chk("R3 pending = src&mask", d, 32'h0000_F000);
        bus_read(a_pend(4), d);
        chk("R3 masked channel pending", d, 32'h0);
        set_src(32'h0);
        bus_read(a_pend(3), d);
        chk("R3 not sticky", d, 32'h0);
        // R4: write to pending changes nothing
        set_src(32'h0000_0010);
        bus_write(a_pend(3), 32'hFFFF_FFFF);
        bus_read(a_mask(3), d);
        chk("R4 mask after pending write", d, mdl[3]);
        chk("R4 irq after pending write", 32'(irq), 32'(exp_irq()));
        set_src(32'h0);
    endtask

    task automatic t_latency();
        mdl[1] = 32'h8000_0000;
        bus_write(a_mask(1), mdl[1]);
        @(negedge clk);
        src = 32'h8000_0000;
        #1 chk("R5 irq before edge", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R5 irq after edge", 32'(irq), 32'h02);
        src = 32'h0;
        #1 chk("R5 irq holds until edge", 32'(irq), 32'h02);
        @(negedge clk);
        chk("R5 irq drops after edge", 32'(irq), 32'h0);
    endtask

    task automatic t_zero_write();
        mdl[2] = 32'h0000_0001;
        bus_write(a_mask(2), mdl[2]);
        set_src(32'h0000_0001);
        @(negedge clk);
        chk("R6 irq set before clear", 32'(irq), 32'(exp_irq()));
        sel = 1'b1; wr = 1'b1; addr = a_mask(2); wdata = 32'h0;
        mdl[2] = 32'h0;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        chk("R6 irq cleared at write edge", 32'(irq), 32'(exp_irq()));
        chk("R9 single-cycle write", 32'(irq[2]), 32'h0);
        set_src(32'h0);
    endtask

    task automatic t_fanout();
        logic [31:0] d;
        mdl[0] = 32'h0000_0400;
        mdl[5] = 32'h0000_0400;
        mdl[7] = 32'h0000_0400;
        bus_write(a_mask(0), mdl[0]);
        bus_write(a_mask(5), mdl[5]);
        bus_write(a_mask(7), mdl[7]);
        set_src(32'h0000_0400);
        @(negedge clk);
        chk("R7 one source to three channels", 32'(irq), 32'h0000_00A1);
        bus_read(a_pend(7), d);
        chk("R7 pending on channel 7", d, 32'h0000_0400);
        set_src(32'h0000_0800);
        @(negedge clk);
        chk("R7 other source masked everywhere", 32'(irq), 32'(exp_irq()));
        set_src(32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic [11:0] bad [6] = '{12'h000, 12'h011, 12'h014, 12'h030, 12'h210, 12'hFE0};
        foreach (bad[k]) begin
            bus_write(bad[k], 32'hFFFF_FFFF);
            bus_read(bad[k], d);
            chk("R8 unmapped read zero", d, 32'h0);
        end
        for (int c = 0; c < 8; c++) begin
            bus_read(a_mask(c), d);
            chk("R8 unmapped write no effect", d, mdl[c]);
        end
        set_src(32'hFFFF_FFFF);
        @(negedge clk);
        chk("R8 irq unchanged", 32'(irq), 32'(exp_irq()));
        set_src(32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) mdl[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_pending();
        t_latency();
        t_zero_write();
        t_fanout();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule